// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block is a small translation cache that sits between a requester issuing virtual addresses and an external page-table walker. Each request carries a virtual address and a write flag. The page number above the 12-bit offset is split in two: the low bits pick a set and the high bits are compared against the tags stored in every way of that set. When a usable entry matches, the physical address and the entry's permission bits are returned in the same cycle. The offset is passed through unchanged.

When nothing usable matches, the block asks the walker for a translation and installs the result. It then completes the request that is still being held. A write to an entry whose dirty bit is clear counts as a miss, so the walker can mark the page dirty in memory. Two flush controls invalidate entries: one spares entries marked global and the other clears everything.

The request side is a valid/ready stream:
- The requester holds `req_valid`, `req_vaddr` and `req_write` steady until `req_ready` is seen.
- `req_ready` rises only in a cycle where the response is valid.
- The walk request holds `walk_valid` and `walk_vpn` until `walk_ready`.
- The fill side accepts data only while `fill_ready` is high.
- A walker must return a dirty bit of 1 for a fill that answers a write.

Top module: `tlb_xlate`

## Requirements
- R1: A request whose set holds a valid entry with an equal tag (and, for a write, a set dirty bit) completes in the same cycle. In that cycle `resp_valid` and `req_ready` are 1, and `resp_paddr` = {stored PPN, `req_vaddr[11:0]`}.
- R2: The set index is `req_vaddr[15:12]` and the tag is `req_vaddr[31:16]`. An address with the same index but a different tag misses, and so does an address with the same tag but a different index.
- R3: On a miss, `walk_valid` rises one cycle later with `walk_vpn` = `req_vaddr[31:12]` and `walk_write` = `req_write`, and holds until `walk_ready`. In the following cycle `fill_ready` is 1 until `fill_valid`. At most one of `walk_valid`, `fill_ready` and `resp_valid` is high at a time.
- R4: In the cycle after the fill handshake, the held request completes with the PPN and permissions just installed.
- R5: On completion, `resp_writable` and `resp_user` equal the stored write-permission and user-access bits of the hit entry.
- R6: A write that matches an entry with dirty = 0 is handled as a miss with `walk_write` = 1. Its fill overwrites that same way, and the other ways of the set are kept.
- R7: A fill with no matching way goes to the lowest-numbered invalid way. When all ways are valid, it goes to the way named by a per-set rotating pointer, which starts at 0 and advances by one on each such eviction.
- R8: A one-cycle `flush` invalidates every entry whose global bit is 0. Global entries still hit afterwards.
- R9: `flush_all` invalidates every entry, so no request hits in the following cycle unless a fill lands in the same cycle.
- R10: After reset every entry is invalid, and `walk_valid`, `fill_ready`, `req_ready` and `resp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request completed this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Request is a store |
| resp_valid | output | 1 | Response fields valid (same cycle as hit) |
| resp_paddr | output | 32 | Translated physical address |
| resp_writable | output | 1 | Entry permits writes |
| resp_user | output | 1 | Entry permits user-mode access |
| walk_valid | output | 1 | Walk request to external walker |
| walk_ready | input | 1 | Walker accepts the request |
| walk_vpn | output | 20 | Page number to walk |
| walk_write | output | 1 | Walk was caused by a store |
| fill_valid | input | 1 | Walker returns an entry |
| fill_ready | output | 1 | Block waiting for the fill |
| fill_ppn | input | 20 | Returned physical page number |
| fill_writable | input | 1 | Returned write permission |
| fill_user | input | 1 | Returned user-access permission |
| fill_dirty | input | 1 | Returned dirty bit |
| fill_global | input | 1 | Returned global bit |
| flush | input | 1 | Invalidate non-global entries |
| flush_all | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 12-bit offset, 16 sets and 4 ways. With only four ways, a fifth distinct tag in one set forces an eviction. This makes the rotating pointer visible at the ports after a few accesses, and the invalid-first choice visible after a partial flush. Sixteen sets let neighbouring indices with equal tags show that the index and tag fields are decoded separately.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_WALK = 2'd1,
    MS_FILL = 2'd2
  } miss_state_e;

endpackage

// File: rtl/tlb_way_cmp.sv
module tlb_way_cmp #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16
) (
  input  logic [WAYS-1:0]            way_vld,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           probe_tag,
  output logic [WAYS-1:0]            match
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = way_vld[w] && (way_tag[w] == probe_tag);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS = 4,
  localparam int WB  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] way_vld,
  input  logic [WB-1:0]   rr_ptr,
  output logic [WB-1:0]   victim,
  output logic            from_ptr
);
  always_comb begin
    victim   = rr_ptr;
    from_ptr = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_vld[w]) begin
        victim   = WB'(w);
        from_ptr = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_miss_fsm.sv
module tlb_miss_fsm
  import tlb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic walk_ready,
  input  logic fill_valid,
  output logic idle,
  output logic walk_valid,
  output logic fill_ready,
  output logic fill_fire
);
  miss_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MS_IDLE: if (start)      st_d = MS_WALK;
      MS_WALK: if (walk_ready) st_d = MS_FILL;
      MS_FILL: if (fill_valid) st_d = MS_IDLE;
      default:                 st_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= MS_IDLE;
    else        st_q <= st_d;
  end

  assign idle       = (st_q == MS_IDLE);
  assign walk_valid = (st_q == MS_WALK);
  assign fill_ready = (st_q == MS_FILL);
  assign fill_fire  = fill_ready && fill_valid;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WB    = $clog2(WAYS),
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int PPN_W = PA_W - PAGE_W,
  localparam int TAG_W = VPN_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_writable,
  output logic             resp_user,
  output logic             walk_valid,
  input  logic             walk_ready,
  output logic [VPN_W-1:0] walk_vpn,
  output logic             walk_write,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_writable,
  input  logic             fill_user,
  input  logic             fill_dirty,
  input  logic             fill_global,
  input  logic             flush,
  input  logic             flush_all
);
  // entry storage, one bit-plane per field
  logic [SETS-1:0][WAYS-1:0]             vld_q, glb_q, drt_q, usr_q, wrt_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn_q;
  logic [SETS-1:0][WB-1:0]               rr_q;

  // captured miss
  logic [VPN_W-1:0] cap_vpn_q;
  logic             cap_wr_q;

  // lookup path
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  lk_match;
  logic [PPN_W-1:0] lk_ppn;
  logic             lk_wrt, lk_usr, lk_drt, lk_hit, lk_usable;

  assign lk_idx = req_vaddr[PAGE_W +: IDX_W];
  assign lk_tag = req_vaddr[VA_W-1 -: TAG_W];

  tlb_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_cmp (
    .way_vld   (vld_q[lk_idx]),
    .way_tag   (tag_q[lk_idx]),
    .probe_tag (lk_tag),
    .match     (lk_match)
  );

  always_comb begin
    lk_ppn = '0;
    lk_wrt = 1'b0;
    lk_usr = 1'b0;
    lk_drt = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) begin
        lk_ppn = lk_ppn | ppn_q[lk_idx][w];
        lk_wrt = lk_wrt | wrt_q[lk_idx][w];
        lk_usr = lk_usr | usr_q[lk_idx][w];
        lk_drt = lk_drt | drt_q[lk_idx][w];
      end
    end
  end

  assign lk_hit    = |lk_match;
  assign lk_usable = lk_hit && (!req_write || lk_drt);

  // miss sequencing
  logic idle, fill_fire, miss_start;

  assign miss_start = idle && req_valid && !lk_usable;

  tlb_miss_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (miss_start),
    .walk_ready (walk_ready),
    .fill_valid (fill_valid),
    .idle       (idle),
    .walk_valid (walk_valid),
    .fill_ready (fill_ready),
    .fill_fire  (fill_fire)
  );

  assign resp_valid    = idle && req_valid && lk_usable;
  assign req_ready     = resp_valid;
  assign resp_paddr    = {lk_ppn, req_vaddr[PAGE_W-1:0]};
  assign resp_writable = lk_wrt;
  assign resp_user     = lk_usr;
  assign walk_vpn      = cap_vpn_q;
  assign walk_write    = cap_wr_q;

  // fill path: reuse a matching way, else choose a victim
  logic [IDX_W-1:0] fl_idx;
  logic [TAG_W-1:0] fl_tag;
  logic [WAYS-1:0]  fl_match;
  logic [WB-1:0]    fl_match_way, fl_victim, fl_way;
  logic             fl_from_ptr, fl_bump;

  assign fl_idx = cap_vpn_q[IDX_W-1:0];
  assign fl_tag = cap_vpn_q[VPN_W-1 -: TAG_W];

  tlb_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_cmp (
    .way_vld   (vld_q[fl_idx]),
    .way_tag   (tag_q[fl_idx]),
    .probe_tag (fl_tag),
    .match     (fl_match)
  );

  tlb_victim #(.WAYS(WAYS)) u_victim (
    .way_vld  (vld_q[fl_idx]),
    .rr_ptr   (rr_q[fl_idx]),
    .victim   (fl_victim),
    .from_ptr (fl_from_ptr)
  );

  always_comb begin
    fl_match_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (fl_match[w]) fl_match_way = WB'(w);
    end
  end

  assign fl_way  = (|fl_match) ? fl_match_way : fl_victim;
  assign fl_bump = !(|fl_match) && fl_from_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= '0;
      glb_q     <= '0;
      drt_q     <= '0;
      usr_q     <= '0;
      wrt_q     <= '0;
      tag_q     <= '0;
      ppn_q     <= '0;
      rr_q      <= '0;
      cap_vpn_q <= '0;
      cap_wr_q  <= 1'b0;
    end else begin
      if (flush_all) begin
        vld_q <= '0;
      end else if (flush) begin
        for (int s = 0; s < SETS; s++) begin
          for (int w = 0; w < WAYS; w++) begin
            if (!glb_q[s][w]) vld_q[s][w] <= 1'b0;
          end
        end
      end
      if (fill_fire) begin
        vld_q[fl_idx][fl_way] <= 1'b1;
        tag_q[fl_idx][fl_way] <= fl_tag;
        ppn_q[fl_idx][fl_way] <= fill_ppn;
        wrt_q[fl_idx][fl_way] <= fill_writable;
        usr_q[fl_idx][fl_way] <= fill_user;
        drt_q[fl_idx][fl_way] <= fill_dirty;
        glb_q[fl_idx][fl_way] <= fill_global;
        if (fl_bump) begin
          rr_q[fl_idx] <= (rr_q[fl_idx] == WB'(WAYS - 1)) ? '0 : rr_q[fl_idx] + 1'b1;
        end
      end
      if (miss_start) begin
        cap_vpn_q <= req_vaddr[VA_W-1:PAGE_W];
        cap_wr_q  <= req_write;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [VA_W-1:0]        req_vaddr,
  input logic                   resp_valid,
  input logic [PA_W-1:0]        resp_paddr,
  input logic                   walk_valid,
  input logic                   walk_ready,
  input logic [VA_W-PAGE_W-1:0] walk_vpn,
  input logic                   fill_valid,
  input logic                   fill_ready,
  input logic                   flush_all
);
  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (req_valid && resp_paddr[PAGE_W-1:0] == req_vaddr[PAGE_W-1:0]));

  assert_walk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && !walk_ready) |=> (walk_valid && $stable(walk_vpn)));

  assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({walk_valid, fill_ready, resp_valid}));

  assert_walk_vpn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid |-> (walk_vpn == req_vaddr[VA_W-1:PAGE_W]));

  assert_flush_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !(fill_valid && fill_ready)) |=> !resp_valid);
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_vaddr  (req_vaddr),
  .resp_valid (resp_valid),
  .resp_paddr (resp_paddr),
  .walk_valid (walk_valid),
  .walk_ready (walk_ready),
  .walk_vpn   (walk_vpn),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .flush_all  (flush_all)
);

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, resp_valid, resp_writable, resp_user;
  logic [31:0] resp_paddr;
  logic        walk_valid, walk_write, fill_ready;
  logic        walk_ready = 1'b0;
  logic [19:0] walk_vpn;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_ppn = '0;
  logic        fill_writable = 1'b0, fill_user = 1'b0, fill_dirty = 1'b0, fill_global = 1'b0;
  logic        flush = 1'b0, flush_all = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tlb_xlate u_tlb_xlate (.*);

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        miss;
    logic [19:0] ppn;
    logic        rw;
    logic        us;
    logic        dr;
    logic        gl;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 1'b0, 1'b1, 20'hAAAAA, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 R4 first miss
    '{32'h1234_5678, 1'b0, 1'b0, 20'hAAAAA, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 hit
    '{32'h1234_5FFF, 1'b0, 1'b0, 20'hAAAAA, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 offset edge
    '{32'h9999_5000, 1'b0, 1'b1, 20'h11111, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 same index
    '{32'h1234_6000, 1'b0, 1'b1, 20'h22222, 1'b1, 1'b0, 1'b1, 1'b0}, // R2 same tag
    '{32'h1234_5010, 1'b1, 1'b1, 20'hAAAAB, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 clean write
    '{32'h1234_5020, 1'b1, 1'b0, 20'hAAAAB, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 dirty write hit
    '{32'h9999_5000, 1'b0, 1'b0, 20'h11111, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 R6 other way kept
    '{32'h1234_6ABC, 1'b1, 1'b0, 20'h22222, 1'b1, 1'b0, 1'b1, 1'b0}  // R5 perms
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] va, input logic wr, input logic exp_miss,
                        input logic [19:0] ppn, input logic rw, input logic us,
                        input logic dr, input logic gl, input string rq);
    logic got_miss;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    #1;
    got_miss = !resp_valid;
    chk(got_miss == exp_miss, rq, "miss", 32'(got_miss), 32'(exp_miss));
    if (got_miss) begin
      @(negedge clk);
      chk(walk_valid && walk_vpn == va[31:12], rq, "walk_vpn", {11'b0, walk_valid, walk_vpn}, {12'h001, va[31:12]});
      chk(walk_write == wr, rq, "walk_write", 32'(walk_write), 32'(wr));
      walk_ready = 1'b1;
      @(negedge clk);
      walk_ready = 1'b0;
      chk(fill_ready && !walk_valid, rq, "fill_ready", 32'(fill_ready), 32'd1);
      fill_valid = 1'b1; fill_ppn = ppn; fill_writable = rw;
      fill_user = us; fill_dirty = dr; fill_global = gl;
      @(negedge clk);
      fill_valid = 1'b0;
      #1;
    end
    chk(resp_valid && req_ready, rq, "complete", {30'b0, resp_valid, req_ready}, 32'd3);
    chk(resp_paddr == {ppn, va[11:0]}, rq, "paddr", resp_paddr, {ppn, va[11:0]});
    chk({resp_writable, resp_user} == {rw, us}, rq, "perms",
        32'({resp_writable, resp_user}), 32'({rw, us}));
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  function automatic logic [31:0] va_of(input logic [15:0] tag, input logic [3:0] idx);
    return {tag, idx, 12'h000};
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!walk_valid && !fill_ready && !req_ready && !resp_valid, "R10", "idle outputs",
        {28'b0, walk_valid, fill_ready, req_ready, resp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].va, VECS[i].wr, VECS[i].miss, VECS[i].ppn,
             VECS[i].rw, VECS[i].us, VECS[i].dr, VECS[i].gl, $sformatf("R1/R2/R4 vec%0d", i));
    end

    // R7 eviction order in set 10
    for (int t = 1; t <= 4; t++) access(va_of(16'(t), 4'hA), 1'b0, 1'b1, 20'h50000 + 20'(t), 1, 1, 0, 0, "R7 fill");
    access(va_of(16'd5, 4'hA), 1'b0, 1'b1, 20'h50005, 1, 1, 0, 0, "R7 evict way0");
    access(va_of(16'd2, 4'hA), 1'b0, 1'b0, 20'h50002, 1, 1, 0, 0, "R7 tag2 kept");
    access(va_of(16'd1, 4'hA), 1'b0, 1'b1, 20'h50001, 1, 1, 0, 0, "R7 tag1 evicted");
    access(va_of(16'd3, 4'hA), 1'b0, 1'b0, 20'h50003, 1, 1, 0, 0, "R7 tag3 kept");
    access(va_of(16'd2, 4'hA), 1'b0, 1'b1, 20'h50002, 1, 1, 0, 0, "R7 ptr advanced");

    // set 11 before flush: global, plain, global
    access(va_of(16'd1, 4'hB), 1'b0, 1'b1, 20'h60001, 1, 0, 0, 1, "R8 setup");
    access(va_of(16'd2, 4'hB), 1'b0, 1'b1, 20'h60002, 1, 0, 0, 0, "R8 setup");
    access(va_of(16'd3, 4'hB), 1'b0, 1'b1, 20'h60003, 1, 0, 0, 1, "R8 setup");

    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    access(32'h9999_5000, 1'b0, 1'b0, 20'h11111, 0, 0, 0, 1, "R8 global kept");
    access(32'h1234_5678, 1'b0, 1'b1, 20'h33333, 1, 1, 0, 0, "R8 plain cleared");
    access(va_of(16'd2, 4'hB), 1'b0, 1'b1, 20'h60012, 1, 0, 0, 0, "R8 plain cleared");
    access(va_of(16'd1, 4'hB), 1'b0, 1'b0, 20'h60001, 1, 0, 0, 1, "R7 invalid way first");
    access(va_of(16'd3, 4'hB), 1'b0, 1'b0, 20'h60003, 1, 0, 0, 1, "R7 invalid way first");

    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
    access(32'h9999_5000, 1'b0, 1'b1, 20'h44444, 1, 1, 0, 0, "R9 global cleared");
    access(va_of(16'd3, 4'hA), 1'b0, 1'b1, 20'h70003, 0, 1, 0, 0, "R9 all cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule